// File: doc/BRIEF.md
# Programmable Interval Timer

This block holds a set of 16-bit down-counters that advance on a slow input tick (about 1.19 MHz, delivered as a one-clock enable `tickEn` in the system clock domain). Software programs it through a byte-wide port. Offsets 0 to 2 reach the data of counters 0 to 2, and offset 3 takes a control word. A control word picks a counter, its byte-access style and its output mode. It can instead freeze the counter's value for a consistent two-byte read. Each counter drives an output pin in one of three modes: one-shot, rate generator or square wave.

Counter 0 raises an interrupt request pulse at each terminal count. Counter 2 counts only while an enable bit is set in a small system control register. That register also reports counter 2's output pin. Counting is always binary, and there is no read-back command.

Top module: `interval_timer`

## Requirements
- R1: The control word at offset 3 holds the counter select in bits [7:6], the access select in bits [5:4], the mode in bits [3:1] and a BCD flag in bit 0. The BCD flag is ignored. A select of 3 has no effect on any counter.
- R2: Access select 3 means low byte then high byte. Each counter has a byte pointer that starts at the low byte after a control word. In this mode the pointer toggles on every data read or write. The new count loads, and the counter restarts, only when the high byte is written. Access select 1 writes and reads only the low byte, and access select 2 only the high byte. In these two single-byte modes each write loads at once and keeps the other byte of the previous count.
- R3: Access select 0 latches the present count. Later reads return the latched value until its high byte has been read. A second latch command issued while a latch is pending is ignored.
- R4: A control word with a non-zero access select drives that counter's output pin to 0 on the next clock. It also stops the counter until a new count is loaded.
- R5: Mode 0 is one-shot. The output stays 0 after the load, goes to 1 on the tick that brings the count to 0, and the counter then stops at 0.
- R6: Mode 2 is the rate generator. After a load the output is 1. It drops to 0 for the one tick period during which the count is 1. On the next tick the count reloads and the output returns to 1. The period is N ticks.
- R7: Mode 3 is the square wave. After a load the output is 1. The output toggles on every reload, which happens every N ticks.
- R8: A loaded count of 0 acts as 65536, so the first tick after such a load gives 0xFFFF.
- R9: `irqReq` is high for exactly one clock after each tick on which counter 0 passes from count 1 to its terminal count or reload.
- R10: Counter 2 counts only while system control bit 0 is 1. While that bit is 0, a read of counter 2 returns its loaded initial count and counter 2's output pin holds.
- R11: Only bits [3:0] of the system control register can be written. A read returns those bits, plus counter 2's output in bit 5 when bit 0 is 1 (0 otherwise). Every other bit reads as 0.
- R12: Counts and output pins change only on a clock with `tickEn` high or with a bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-clock strobe per counting tick |
| busWr | input | 1 | Write strobe for the counter port |
| busRd | input | 1 | Read strobe for the counter port; it moves the byte pointer and releases latches |
| busAddr | input | 2 | Offset: 0 to 2 select counter data, 3 selects the control word |
| busWrData | input | 8 | Write byte |
| busRdData | output | 8 | Read byte for the current offset (combinational) |
| sysWr | input | 1 | Write strobe for the system control register |
| sysWrData | input | 8 | System control write byte; only bits [3:0] are kept |
| sysRdData | output | 8 | System control register read value |
| cntOut | output | 3 | Output pins, one bit per counter |
| irqReq | output | 1 | Interrupt request pulse from counter 0 |

## Verification
The rate generator is tried with random initial counts and random tick runs of up to three periods. These runs separate a correct modulo reload from an off-by-one period, and they also check the interrupt count against the number of whole periods. Idle gaps with `tickEn` low sit between those runs to expose any counting on the plain clock. Directed sequences cover the remaining cases:
- every access style, which tells a premature load after the low byte apart from a correct one;
- a latch held across ticks, a repeated latch and a release, which tells frozen reads from live ones;
- a gate toggled while counter 2 is loaded, which tells held counting and the initial-count read apart from free running;
- a count of zero, which checks the 65536 wrap.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } accMode_t;

  typedef enum logic [1:0] {
    MD_ONESHOT = 2'd0,
    MD_RATE    = 2'd1,
    MD_SQUARE  = 2'd2
  } cntMode_t;

  // Strobes and steady configuration from control to datapath, per counter
  typedef struct packed {
    logic     cfgWr;
    logic     latchCmd;
    logic     wrLo;
    logic     wrHi;
    logic     load;
    logic     relLatch;
    cntMode_t mode;
  } cntStrobe_t;

  function automatic cntMode_t decodeMode(input logic [2:0] field);
    case (field[1:0])
      2'b10:   return MD_RATE;
      2'b11:   return MD_SQUARE;
      default: return MD_ONESHOT;
    endcase
  endfunction

endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int NUM_CNT  = 3,
  parameter int CNT_W    = 16,
  parameter int GATE_IDX = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busWr,
  input  logic                          busRd,
  input  logic [$clog2(NUM_CNT+1)-1:0]  busAddr,
  input  logic [CNT_W/2-1:0]            busWrData,
  input  logic                          sysWr,
  input  logic [CNT_W/2-1:0]            sysWrData,
  input  logic                          gateOut,
  input  logic [CNT_W-1:0]              rdVal [NUM_CNT],
  output cntStrobe_t                    strobe [NUM_CNT],
  output logic [CNT_W/2-1:0]            busRdData,
  output logic [CNT_W/2-1:0]            sysRdData,
  output logic                          gateEn
);

  localparam int BYTE_W  = CNT_W / 2;
  localparam int ADDR_W  = $clog2(NUM_CNT + 1);
  localparam int CTL_OFS = NUM_CNT;
  localparam int SYS_W   = 4;

  logic [SYS_W-1:0]   sysLow;
  logic [NUM_CNT-1:0] hiSel;
  logic               cfgHit;
  logic [1:0]         selField;
  logic [1:0]         accField;

  assign cfgHit   = busWr && (busAddr == ADDR_W'(CTL_OFS));
  assign selField = busWrData[7:6];
  assign accField = busWrData[5:4];
  assign gateEn   = sysLow[0];

  always_ff @(posedge clk) begin
    if (!rstN) sysLow <= '0;
    else if (sysWr) sysLow <= sysWrData[SYS_W-1:0];
  end

  assign sysRdData = BYTE_W'({2'b00, gateEn & gateOut, 1'b0, sysLow});

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cfg
    accMode_t accMode;
    cntMode_t modeQ;
    logic     ptrHi;
    logic     cfgSel;
    logic     dataWr;
    logic     dataRd;

    assign cfgSel   = cfgHit && (selField == 2'(k));
    assign dataWr   = busWr && (busAddr == ADDR_W'(k));
    assign dataRd   = busRd && (busAddr == ADDR_W'(k));
    assign hiSel[k] = (accMode == ACC_HI) || ((accMode == ACC_WORD) && ptrHi);

    assign strobe[k] = '{
      cfgWr:    cfgSel && (accField != 2'd0),
      latchCmd: cfgSel && (accField == 2'd0),
      wrLo:     dataWr && !hiSel[k],
      wrHi:     dataWr && hiSel[k],
      load:     dataWr && ((accMode != ACC_WORD) || ptrHi),
      relLatch: dataRd && hiSel[k],
      mode:     modeQ
    };

    always_ff @(posedge clk) begin
      if (!rstN) begin
        accMode <= ACC_WORD;
        modeQ   <= MD_ONESHOT;
        ptrHi   <= 1'b0;
      end else if (cfgSel && (accField != 2'd0)) begin
        accMode <= accMode_t'(accField);
        modeQ   <= decodeMode(busWrData[3:1]);
        ptrHi   <= 1'b0;
      end else if ((dataWr || dataRd) && (accMode == ACC_WORD)) begin
        ptrHi <= ~ptrHi;
      end
    end
  end

  always_comb begin
    busRdData = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (busAddr == ADDR_W'(k)) begin
        busRdData = hiSel[k] ? rdVal[k][CNT_W-1:BYTE_W] : rdVal[k][BYTE_W-1:0];
      end
    end
  end

endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int NUM_CNT  = 3,
  parameter int CNT_W    = 16,
  parameter int GATE_IDX = 2,
  parameter int IRQ_IDX  = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 gateEn,
  input  logic [CNT_W/2-1:0]   wrByte,
  input  cntStrobe_t           strobe [NUM_CNT],
  output logic [CNT_W-1:0]     rdVal [NUM_CNT],
  output logic [NUM_CNT-1:0]   cntOut,
  output logic                 irqReq
);

  localparam int BYTE_W = CNT_W / 2;

  logic [NUM_CNT-1:0] tcHit;

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  initVal;
    logic [CNT_W-1:0]  latchVal;
    logic [CNT_W-1:0]  newInit;
    logic [BYTE_W-1:0] pendLo;
    logic              latched;
    logic              running;
    logic              outQ;
    logic              enabled;
    logic              stepOk;

    if (k == GATE_IDX) begin : g_gated
      assign enabled = gateEn;
    end else begin : g_free
      assign enabled = 1'b1;
    end

    assign newInit = strobe[k].wrHi ? {wrByte, pendLo}
                                    : {initVal[CNT_W-1:BYTE_W], wrByte};
    assign stepOk   = tickEn && running && enabled;
    assign tcHit[k] = stepOk && (count == CNT_W'(1)) && !strobe[k].load && !strobe[k].cfgWr;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        count    <= '0;
        initVal  <= '0;
        latchVal <= '0;
        pendLo   <= '0;
        latched  <= 1'b0;
        running  <= 1'b0;
        outQ     <= 1'b0;
      end else begin
        if (strobe[k].wrLo) pendLo <= wrByte;

        if (strobe[k].cfgWr) begin
          outQ    <= 1'b0;
          running <= 1'b0;
        end else if (strobe[k].load) begin
          initVal <= newInit;
          pendLo  <= newInit[BYTE_W-1:0];
          count   <= newInit;
          running <= 1'b1;
          outQ    <= (strobe[k].mode != MD_ONESHOT);
        end else if (stepOk) begin
          case (strobe[k].mode)
            MD_ONESHOT: begin
              if (count == CNT_W'(1)) begin
                count   <= '0;
                outQ    <= 1'b1;
                running <= 1'b0;
              end else begin
                count <= count - 1'b1;
              end
            end
            MD_RATE: begin
              if (count == CNT_W'(1)) begin
                count <= initVal;
                outQ  <= 1'b1;
              end else begin
                count <= count - 1'b1;
                if (count == CNT_W'(2)) outQ <= 1'b0;
              end
            end
            default: begin
              if (count == CNT_W'(1)) begin
                count <= initVal;
                outQ  <= ~outQ;
              end else begin
                count <= count - 1'b1;
              end
            end
          endcase
        end

        if (strobe[k].latchCmd && !latched) begin
          latched  <= 1'b1;
          latchVal <= count;
        end else if (strobe[k].relLatch) begin
          latched <= 1'b0;
        end
      end
    end

    assign rdVal[k]  = !enabled ? initVal : (latched ? latchVal : count);
    assign cntOut[k] = outQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqReq <= 1'b0;
    else       irqReq <= tcHit[IRQ_IDX];
  end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import pit_pkg::*;
#(
  parameter int NUM_CNT  = 3,
  parameter int CNT_W    = 16,
  parameter int GATE_IDX = 2,
  parameter int IRQ_IDX  = 0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tickEn,
  input  logic                          busWr,
  input  logic                          busRd,
  input  logic [$clog2(NUM_CNT+1)-1:0]  busAddr,
  input  logic [CNT_W/2-1:0]            busWrData,
  output logic [CNT_W/2-1:0]            busRdData,
  input  logic                          sysWr,
  input  logic [CNT_W/2-1:0]            sysWrData,
  output logic [CNT_W/2-1:0]            sysRdData,
  output logic [NUM_CNT-1:0]            cntOut,
  output logic                          irqReq
);

  cntStrobe_t       strobe [NUM_CNT];
  logic [CNT_W-1:0] rdVal  [NUM_CNT];
  logic             gateEn;

  pit_ctrl #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .GATE_IDX(GATE_IDX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .sysWr(sysWr), .sysWrData(sysWrData),
    .gateOut(cntOut[GATE_IDX]), .rdVal(rdVal), .strobe(strobe),
    .busRdData(busRdData), .sysRdData(sysRdData), .gateEn(gateEn)
  );

  pit_datapath #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .GATE_IDX(GATE_IDX), .IRQ_IDX(IRQ_IDX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .gateEn(gateEn),
    .wrByte(busWrData), .strobe(strobe), .rdVal(rdVal),
    .cntOut(cntOut), .irqReq(irqReq)
  );

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int NUM_CNT  = 3,
  parameter int CNT_W    = 16,
  parameter int GATE_IDX = 2
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          tickEn,
  input logic                          busWr,
  input logic [$clog2(NUM_CNT+1)-1:0]  busAddr,
  input logic [CNT_W/2-1:0]            busWrData,
  input logic                          sysWr,
  input logic [CNT_W/2-1:0]            sysRdData,
  input logic [NUM_CNT-1:0]            cntOut,
  input logic                          irqReq
);

  localparam int ADDR_W = $clog2(NUM_CNT + 1);

  // R9: an interrupt pulse only follows a clock that carried a tick
  assert_irq_after_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> $past(tickEn));

  // R11: status layout of the system control register
  assert_sys_layout_R11: assert property (@(posedge clk) disable iff (!rstN)
    (sysRdData[7:6] == 2'b00) && !sysRdData[4] && (!sysRdData[5] || sysRdData[0]));

  // R12: no tick and no bus write keeps every output pin
  assert_out_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !busWr) |=> $stable(cntOut));

  // R10: a disabled gated counter holds its pin
  assert_gate_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!sysRdData[0] && !sysWr && !busWr) |=> $stable(cntOut[GATE_IDX]));

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_chk
    // R4: a configuring control word clears the selected pin
    assert_cfg_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && (busAddr == ADDR_W'(NUM_CNT)) && (busWrData[7:6] == 2'(k)) &&
       (busWrData[5:4] != 2'b00)) |=> !cntOut[k]);
  end

endmodule

bind interval_timer interval_timer_chk #(
  .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .GATE_IDX(GATE_IDX)
) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWr(busWr), .busAddr(busAddr),
  .busWrData(busWrData), .sysWr(sysWr), .sysRdData(sysRdData),
  .cntOut(cntOut), .irqReq(irqReq)
);

// File: tb/tb_interval_timer.sv
module tb_interval_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       sysWr = 1'b0;
  logic [7:0] sysWrData = '0;
  logic [7:0] sysRdData;
  logic [2:0] cntOut;
  logic       irqReq;

  int nChecks = 0;
  int nFail   = 0;
  int irqCnt  = 0;
  bit done    = 1'b0;

  interval_timer dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .sysWr(sysWr), .sysWrData(sysWrData), .sysRdData(sysRdData),
    .cntOut(cntOut), .irqReq(irqReq)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (rstN && irqReq) irqCnt++;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk); busWr = 1'b0; #1;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); busRd = 1'b1; busAddr = a; #1 d = busRdData;
    @(negedge clk); busRd = 1'b0; #1;
  endtask

  task automatic read16(input logic [1:0] a, output int v);
    logic [7:0] lo, hi;
    busRead(a, lo);
    busRead(a, hi);
    v = {hi, lo};
  endtask

  task automatic sysWrite(input logic [7:0] d);
    @(negedge clk); sysWr = 1'b1; sysWrData = d;
    @(negedge clk); sysWr = 1'b0; #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
    end
    @(negedge clk); tickEn = 1'b0; #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  // Rate generator: count left after n ticks from load value init (init >= 2)
  function automatic int rateRemain(input int init, input int n);
    int r = n % init;
    return (r == 0) ? init : init - r;
  endfunction

  initial begin
    logic [7:0] b;
    int v;
    int init;
    int n;
    int irq0;
    int seed;
    seed = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;

    // reset state
    read16(2'd0, v);
    chk("R12 reset count", v, 0);
    chk("R4 reset pins", cntOut, 0);
    chk("R9 reset irq", irqReq, 0);
    chk("R11 reset sysctl", sysRdData, 0);

    // counter 0, word access, rate generator
    busWrite(2'd3, 8'h34);
    busWrite(2'd0, 8'd10);
    chk("R2 no load after low byte", cntOut[0], 0);
    busWrite(2'd0, 8'd0);
    chk("R6 pin high after load", cntOut[0], 1);
    read16(2'd0, v);
    chk("R2 word readback", v, 10);
    ticks(8);
    read16(2'd0, v);
    chk("R6 count after 8", v, 2);
    chk("R6 pin high at 2", cntOut[0], 1);
    ticks(1);
    chk("R6 pin low at 1", cntOut[0], 0);
    irq0 = irqCnt;
    ticks(1);
    chk("R6 pin back high", cntOut[0], 1);
    read16(2'd0, v);
    chk("R6 reload", v, 10);
    chk("R9 one irq per reload", irqCnt - irq0, 1);

    // latch
    ticks(3);
    busWrite(2'd3, 8'h00);
    ticks(2);
    busWrite(2'd3, 8'h00);
    ticks(1);
    busRead(2'd0, b);
    chk("R3 latched low byte", b, 7);
    ticks(1);
    busRead(2'd0, b);
    chk("R3 latched high byte", b, 0);
    read16(2'd0, v);
    chk("R3 live after release", v, 3);

    // read-back select ignored
    busWrite(2'd3, 8'hF4);
    read16(2'd0, v);
    chk("R1 select 3 ignored count", v, 3);
    chk("R1 select 3 ignored pin", cntOut[0], 1);

    // counter 1, low byte only, one-shot
    busWrite(2'd3, 8'h50);
    busWrite(2'd1, 8'd5);
    chk("R5 pin low after load", cntOut[1], 0);
    busRead(2'd1, b);
    chk("R2 low-only readback", b, 5);
    ticks(4);
    chk("R5 pin low before tc", cntOut[1], 0);
    ticks(1);
    chk("R5 pin high at tc", cntOut[1], 1);
    ticks(3);
    busRead(2'd1, b);
    chk("R5 stopped at zero", b, 0);
    chk("R5 pin stays high", cntOut[1], 1);
    busWrite(2'd3, 8'h50);
    chk("R4 control clears pin", cntOut[1], 0);

    // high byte only keeps low byte
    busWrite(2'd3, 8'h60);
    busWrite(2'd1, 8'h02);
    busRead(2'd1, b);
    chk("R2 high-only readback", b, 2);
    busWrite(2'd3, 8'h50);
    busRead(2'd1, b);
    chk("R2 low byte kept", b, 5);

    // zero count means 65536
    busWrite(2'd3, 8'h70);
    busWrite(2'd1, 8'd0);
    busWrite(2'd1, 8'd0);
    ticks(1);
    read16(2'd1, v);
    chk("R8 wrap from zero", v, 16'hFFFF);

    // square wave on counter 0
    busWrite(2'd3, 8'h36);
    busWrite(2'd0, 8'd4);
    busWrite(2'd0, 8'd0);
    chk("R7 pin high after load", cntOut[0], 1);
    ticks(3);
    chk("R7 pin high before reload", cntOut[0], 1);
    ticks(1);
    chk("R7 pin toggles low", cntOut[0], 0);
    read16(2'd0, v);
    chk("R7 reload value", v, 4);
    ticks(4);
    chk("R7 pin toggles high", cntOut[0], 1);

    // counter 2 gate
    busWrite(2'd3, 8'hB4);
    busWrite(2'd2, 8'd100);
    busWrite(2'd2, 8'd0);
    chk("R11 disabled status", sysRdData, 8'h00);
    ticks(5);
    read16(2'd2, v);
    chk("R10 disabled reads initial", v, 100);
    chk("R10 pin held", cntOut[2], 1);
    sysWrite(8'h01);
    chk("R11 enabled status", sysRdData, 8'h21);
    ticks(5);
    read16(2'd2, v);
    chk("R10 counts when enabled", v, 95);
    sysWrite(8'hF0);
    chk("R11 upper bits not writable", sysRdData, 8'h00);
    ticks(3);
    read16(2'd2, v);
    chk("R10 initial while disabled", v, 100);
    sysWrite(8'hFF);
    chk("R11 low bits and status", sysRdData, 8'h2F);
    read16(2'd2, v);
    chk("R10 held count resumes", v, 95);

    // random rate-generator runs on counter 0
    busWrite(2'd3, 8'h34);
    for (int it = 0; it < 16; it++) begin
      init = 300 + int'($urandom % 700);
      busWrite(2'd0, init[7:0]);
      busWrite(2'd0, init[15:8]);
      n = int'($urandom % (3 * init));
      idle(1 + int'($urandom % 5));
      read16(2'd0, v);
      chk("R12 idle keeps count", v, init);
      irq0 = irqCnt;
      ticks(n);
      read16(2'd0, v);
      chk("R6 random remain", v, rateRemain(init, n));
      chk("R6 random pin", cntOut[0], (rateRemain(init, n) == 1) ? 0 : 1);
      chk("R9 random irq count", irqCnt - irq0, n / init);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule